// File: doc/BRIEF.md
# Audio Bit and Frame Clock Divider

This block derives a serial-audio bit clock and a left/right frame clock from one master audio clock. The master clock runs at a fixed rate. A 2-bit ratio code tells the divider whether that clock is 512 or 256 times the sample rate. With a 24.576 MHz master, the same clock then serves a 48 kHz stream in the 512 ratio and a 96 kHz stream in the 256 ratio. The bit clock always runs at 64 times the sample rate, so each frame-clock half holds 32 bit-clock periods.

Software or a rate detector presents a new code and pulses a strobe. The block accepts the code at once, but the divider changes only at the next frame-clock edge. That edge is also a falling edge of the bit clock. Moving between the two supported ratios therefore never cuts a bit-clock or frame-clock period short. A strobe with an unsupported code raises a lock-error flag and leaves the clocks unchanged. The flag stays set until the next strobe that carries a supported code.

Top module: `abf_clk_div`

## Requirements
- R1: While rst_ni is low and after its release, bclk_o, lrclk_o and lock_err_o are 0 and the active ratio is 512 (code 2'b10).
- R2: With ratio code 2'b10 active, bclk_o has a period of 8 master cycles: low for 4, then high for 4.
- R3: With ratio code 2'b11 active, bclk_o has a period of 4 master cycles: low for 2, then high for 2.
- R4: lrclk_o toggles after every 32 bclk_o periods, only in the same cycle as a falling edge of bclk_o. It starts low (left channel) after reset.
- R5: A strobe carrying code 2'b10 or 2'b11 takes effect only at the next lrclk_o toggle. Until then the previous ratio continues.
- R6: A change between codes 2'b10 and 2'b11, in either direction, gives no bclk_o high or low phase other than 2 or 4 cycles and no shortened lrclk_o half. lock_err_o does not rise.
- R7: A strobe carrying code 2'b00 or 2'b01 sets lock_err_o in the following cycle and leaves the active and pending ratio unchanged.
- R8: lock_err_o holds its value when there is no strobe. It is cleared in the cycle after a strobe that carries code 2'b10 or 2'b11.
- R9: Changes on mode_i while mode_upd_i is low have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master audio clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Ratio code: 2'b10 = 512fs, 2'b11 = 256fs, others invalid |
| mode_upd_i | input | 1 | One-cycle strobe that samples mode_i |
| bclk_o | output | 1 | Bit clock, 64fs |
| lrclk_o | output | 1 | Frame clock: low = left, high = right |
| lock_err_o | output | 1 | Sticky error for an unsupported ratio code |

## Verification
The bound checker watches several properties on every cycle:
- every bclk_o high phase lasts exactly 2 or 4 master cycles, including across a ratio switch;
- lrclk_o moves only together with a falling bit-clock edge;
- lock_err_o sets or clears one cycle after a strobe, according to the code, and holds otherwise.

Some behaviour can only be shown by the bench's scenarios:
- a new ratio waits for the frame boundary;
- a half frame counts exactly 32 bit clocks;
- an invalid code leaves the running ratio alone;
- mode_i is ignored without a strobe.

The bench's cycle-level model, which tracks the master-cycle position within the current half frame, covers these.

// File: rtl/abf_pkg.sv
package abf_pkg;
  localparam logic [1:0] MODE_512 = 2'b10;
  localparam logic [1:0] MODE_256 = 2'b11;

  function automatic logic mode_ok(input logic [1:0] m);
    return m[1];
  endfunction
endpackage

// File: rtl/abf_mode_ctrl.sv
module abf_mode_ctrl
  import abf_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] mode_i,
  input  logic       mode_upd_i,
  input  logic       bound_i,
  output logic       sel256_o,
  output logic       lock_err_o
);
  logic [1:0] pend_q, cur_q;
  logic       err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= MODE_512;
      cur_q  <= MODE_512;
      err_q  <= 1'b0;
    end else begin
      if (mode_upd_i) begin
        if (mode_ok(mode_i)) begin
          pend_q <= mode_i;
          err_q  <= 1'b0;
        end else begin
          err_q  <= 1'b1;
        end
      end
      // ratio only moves on a frame boundary
      if (bound_i) cur_q <= pend_q;
    end
  end

  assign sel256_o   = (cur_q == MODE_256);
  assign lock_err_o = err_q;
endmodule

// File: rtl/abf_bit_div.sv
module abf_bit_div #(
  parameter int DIV_512 = 8,
  parameter int DIV_256 = 4,
  parameter int CNT_W   = $clog2(DIV_512)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sel256_i,
  output logic bclk_o,
  output logic last_o
);
  localparam logic [CNT_W-1:0] LIM_512  = CNT_W'(DIV_512 - 1);
  localparam logic [CNT_W-1:0] LIM_256  = CNT_W'(DIV_256 - 1);
  localparam logic [CNT_W-1:0] HALF_512 = CNT_W'(DIV_512 / 2);
  localparam logic [CNT_W-1:0] HALF_256 = CNT_W'(DIV_256 / 2);

  logic [CNT_W-1:0] cnt_q, lim, half;

  assign lim    = sel256_i ? LIM_256 : LIM_512;
  assign half   = sel256_i ? HALF_256 : HALF_512;
  assign last_o = (cnt_q == lim);
  assign bclk_o = (cnt_q >= half);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (last_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/abf_frame_cnt.sv
module abf_frame_cnt #(
  parameter int HALF_BITS = 32,
  parameter int BIT_W     = $clog2(HALF_BITS)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  output logic lrclk_o,
  output logic bound_o
);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(HALF_BITS - 1);

  logic [BIT_W-1:0] bit_q;
  logic             lr_q;

  assign bound_o = tick_i && (bit_q == LAST_BIT);
  assign lrclk_o = lr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_q <= '0;
      lr_q  <= 1'b0;
    end else if (bound_o) begin
      bit_q <= '0;
      lr_q  <= ~lr_q;
    end else if (tick_i) begin
      bit_q <= bit_q + 1'b1;
    end
  end
endmodule

// File: rtl/abf_clk_div.sv
module abf_clk_div #(
  parameter int DIV_512   = 8,
  parameter int DIV_256   = 4,
  parameter int HALF_BITS = 32
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] mode_i,
  input  logic       mode_upd_i,
  output logic       bclk_o,
  output logic       lrclk_o,
  output logic       lock_err_o
);
  localparam int CNT_W = $clog2(DIV_512);
  localparam int BIT_W = $clog2(HALF_BITS);

  logic sel256, bit_last, bound;

  abf_mode_ctrl u_mode (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mode_i     (mode_i),
    .mode_upd_i (mode_upd_i),
    .bound_i    (bound),
    .sel256_o   (sel256),
    .lock_err_o (lock_err_o)
  );

  abf_bit_div #(.DIV_512(DIV_512), .DIV_256(DIV_256), .CNT_W(CNT_W)) u_bit (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sel256_i (sel256),
    .bclk_o   (bclk_o),
    .last_o   (bit_last)
  );

  abf_frame_cnt #(.HALF_BITS(HALF_BITS), .BIT_W(BIT_W)) u_frame (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (bit_last),
    .lrclk_o (lrclk_o),
    .bound_o (bound)
  );
endmodule

// File: rtl/abf_clk_div_chk.sv
module abf_clk_div_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] mode_i,
  input logic       mode_upd_i,
  input logic       bclk_o,
  input logic       lrclk_o,
  input logic       lock_err_o
);
  logic [3:0] hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     hi_q <= '0;
    else if (bclk_o) hi_q <= hi_q + 1'b1;
    else             hi_q <= '0;
  end

  a_r6_bclk_high_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(bclk_o) |-> (hi_q == 4'd2 || hi_q == 4'd4));

  a_r4_lr_on_bclk_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(lrclk_o) |-> $fell(bclk_o));

  a_r7_err_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_upd_i && !mode_i[1]) |=> lock_err_o);

  a_r8_err_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_upd_i && mode_i[1]) |=> !lock_err_o);

  a_r8_err_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_upd_i |=> $stable(lock_err_o));
endmodule

bind abf_clk_div abf_clk_div_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .mode_i     (mode_i),
  .mode_upd_i (mode_upd_i),
  .bclk_o     (bclk_o),
  .lrclk_o    (lrclk_o),
  .lock_err_o (lock_err_o)
);

// File: tb/sim_abf_clk_div.sv
module sim_abf_clk_div;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode = 2'b10;
  logic       upd = 1'b0;
  logic       bclk, lrclk, lerr;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  abf_clk_div u0 (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .mode_i     (mode),
    .mode_upd_i (upd),
    .bclk_o     (bclk),
    .lrclk_o    (lrclk),
    .lock_err_o (lerr)
  );

  // reference: position in master cycles inside the current frame half
  int m_ph = 0, m_div = 8, m_pend = 8;
  bit m_lr = 0, m_err = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = 0; m_div = 8; m_pend = 8; m_lr = 0; m_err = 0;
    end else begin
      int np;
      bit ne;
      np = m_pend;
      ne = m_err;
      if (upd) begin
        if (mode == 2'b10)      begin np = 8; ne = 0; end
        else if (mode == 2'b11) begin np = 4; ne = 0; end
        else                    ne = 1;
      end
      m_ph++;
      if (m_ph == 32 * m_div) begin
        m_ph = 0;
        m_lr = ~m_lr;
        m_div = m_pend;
      end
      m_pend = np;
      m_err = ne;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      check("R2/R3 bclk", int'(bclk), int'((m_ph % m_div) >= m_div / 2));
      check("R4/R5/R6 lrclk", int'(lrclk), int'(m_lr));
      check("R7/R8 lock_err", int'(lerr), int'(m_err));
    end
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected <100000 cycles", cyc);
      finish_run();
    end
  end

  task automatic strobe(input logic [1:0] code);
    @(negedge clk);
    mode = code;
    upd = 1'b1;
    @(negedge clk);
    upd = 1'b0;
  endtask

  task automatic meas(output int p);
    int n;
    while (bclk) @(negedge clk);
    while (!bclk) @(negedge clk);
    n = 0;
    do begin @(negedge clk); n++; end while (bclk);
    do begin @(negedge clk); n++; end while (!bclk);
    p = n;
  endtask

  task automatic wait_lr();
    logic l;
    l = lrclk;
    while (lrclk == l) @(negedge clk);
  endtask

  initial begin
    int p;
    int rises;
    repeat (3) @(negedge clk);
    check("R1 bclk in reset", int'(bclk), 0);
    check("R1 lrclk in reset", int'(lrclk), 0);
    check("R1 err in reset", int'(lerr), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 lrclk after reset", int'(lrclk), 0);
    meas(p);
    check("R2 period 512fs", p, 8);

    // count bit clocks in one half frame
    wait_lr();
    rises = 0;
    begin
      logic pb, l0;
      pb = bclk;
      l0 = lrclk;
      while (lrclk == l0) begin
        @(negedge clk);
        if (bclk && !pb) rises++;
        pb = bclk;
      end
    end
    check("R4 bclk per half", rises, 32);

    // no strobe: code ignored
    @(negedge clk);
    mode = 2'b11;
    repeat (20) @(negedge clk);
    meas(p);
    check("R9 no strobe", p, 8);
    wait_lr();
    meas(p);
    check("R9 no strobe after boundary", p, 8);

    // valid switch waits for boundary
    wait_lr();
    strobe(2'b11);
    meas(p);
    check("R5 old ratio until boundary", p, 8);
    wait_lr();
    meas(p);
    check("R3 period 256fs", p, 4);
    check("R6 no error on switch", int'(lerr), 0);

    // invalid code
    strobe(2'b01);
    check("R7 err set", int'(lerr), 1);
    meas(p);
    check("R7 ratio unchanged", p, 4);
    wait_lr();
    meas(p);
    check("R7 pending unchanged", p, 4);
    strobe(2'b00);
    repeat (50) @(negedge clk);
    check("R8 err sticky", int'(lerr), 1);
    strobe(2'b10);
    check("R8 err cleared", int'(lerr), 0);
    meas(p);
    check("R5 256fs until boundary", p, 4);
    wait_lr();
    meas(p);
    check("R6 back to 512fs", p, 8);

    // strobe close to a boundary, then back again
    wait_lr();
    repeat (32 * 8 - 4) @(negedge clk);
    strobe(2'b11);
    repeat (600) @(negedge clk);
    strobe(2'b10);
    repeat (1200) @(negedge clk);
    check("R6 final err", int'(lerr), 0);
    finish_run();
  end
endmodule